// File: doc/BRIEF.md
# DMA Request Priority Resolver

This block decides which of several DMA channels gets the system bus, and it runs the bus handover with the CPU. Each channel has its own request line. These lines arrive with no fixed timing relation to the clock, so each one passes through a synchronizer. A request is counted only if software has enabled that channel. When at least one enabled request is pending, the block raises a hold request to the CPU. It then waits for hold acknowledge. After hold acknowledge arrives, it picks one channel and drives that channel's active-low acknowledge line for the whole transfer cycle.

The choice between channels uses one of two rules. In fixed mode, the lowest-numbered channel always wins. In rotating mode, the channel that was just served drops to the lowest priority for the next decision. A ready input adds wait states: while ready is low, the transfer and its grant stay in place. A small configuration write loads the channel enable mask and the mode bit. Reset clears both, so the block starts idle with every channel disabled.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, hold_req is 0, every dack_n bit is 1, all channels are disabled and fixed mode is selected. Requests on disabled channels never raise hold_req.
- R2: Each dreq bit passes through a two-flop synchronizer. A request that appears before clock edge k on an enabled channel raises hold_req after edge k+2. A request on a channel whose enable bit is 0 is ignored.
- R3: No dack_n bit goes low unless hold_ack was 1 in the cycle before the grant began. hold_req stays 1 for as long as any dack_n bit is low.
- R4: At most one dack_n bit is low at any time. Bit i belongs to channel i, and 0 means granted.
- R5: In fixed mode (cfg_rotate = 0), the pending enabled channel with the lowest index is granted.
- R6: In rotating mode (cfg_rotate = 1), the channel just served becomes the lowest priority. The channel with the next higher index (wrapping to 0) becomes the highest priority.
- R7: While ready is 0, the grant holds. The transfer ends at the first clock edge where ready is 1 in the grant cycle, and dack_n then returns to all ones.
- R8: A grant cannot be preempted. A higher-priority request that arrives during a transfer does not change dack_n until that transfer ends.
- R9: hold_req falls after a transfer ends when no enabled request remains.
- R10: A clock edge with cfg_we = 1 loads the enable mask (bit i enables channel i) and the mode bit. It also resets the rotation so that channel 0 is highest again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | NUM_CH | Channel enable mask to load |
| cfg_rotate | input | 1 | Mode to load: 1 selects rotating, 0 selects fixed |
| dreq | input | NUM_CH | Asynchronous channel request lines |
| hold_ack | input | 1 | Bus handed over by the CPU |
| ready | input | 1 | Transfer may complete; low inserts wait states |
| hold_req | output | 1 | Bus request to the CPU |
| dack_n | output | NUM_CH | Active-low per-channel acknowledge |

## Verification
Most internal faults in this block show up quickly at the ports. A corrupted rotation pointer or mode bit shows up as the wrong acknowledge line at the very next grant. This is visible by comparing the order of grants across a held set of requests. A state machine that leaves the transfer state too early, or re-arbitrates during it, shows up within one cycle of a wait state as a dack_n change while ready is low. A synchronizer with the wrong depth moves the rising edge of hold_req by a whole cycle from its expected position. A stale enable register shows up as a hold request raised for a disabled channel.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_ACK = 2'd1,
      ST_XFER     = 2'd2
   } bus_st_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dma_req_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  pend,
   input  logic [IW-1:0] top_idx,
   output logic          valid,
   output logic [IW-1:0] win
);
   always_comb begin
      valid = 1'b0;
      win   = top_idx;
      // scan from lowest priority to highest so the highest pending one is kept last
      for (int k = N - 1; k >= 0; k--) begin
         automatic int t = int'(top_idx) + k;
         if (t >= N) t = t - N;
         if (pend[t]) begin
            valid = 1'b1;
            win   = IW'(t);
         end
      end
   end

   always_comb begin
      if (valid) begin
         p_win_is_pending_r5: assert (pend[win]);
      end
   end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_prio_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [NUM_CH-1:0] cfg_enable,
   input  logic              cfg_rotate,
   input  logic [NUM_CH-1:0] dreq,
   input  logic              hold_ack,
   input  logic              ready,
   output logic              hold_req,
   output logic [NUM_CH-1:0] dack_n
);
   localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [IW-1:0] LAST_CH = IW'(NUM_CH - 1);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_prio_arbiter: NUM_CH must be at least 2");
   end

   logic [NUM_CH-1:0] req_s;
   logic [NUM_CH-1:0] en_q;
   logic              rot_q;
   logic [IW-1:0]     ptr_q;
   logic [IW-1:0]     gnt_q;
   bus_st_e           st_q;
   logic [NUM_CH-1:0] pending;
   logic              any_req;
   logic              pick_valid;
   logic [IW-1:0]     pick_idx;
   logic [IW-1:0]     top_idx;
   logic              dack_act;

   dma_req_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (dreq),
      .d_sync  (req_s)
   );

   assign pending = req_s & en_q;
   assign any_req = |pending;
   assign top_idx = rot_q ? ptr_q : '0;

   dma_prio_pick #(.N(NUM_CH)) u_pick (
      .pend    (pending),
      .top_idx (top_idx),
      .valid   (pick_valid),
      .win     (pick_idx)
   );

   // mode set register and rotation pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         rot_q <= 1'b0;
         ptr_q <= '0;
      end else if (cfg_we) begin
         en_q  <= cfg_enable;
         rot_q <= cfg_rotate;
         ptr_q <= '0;
      end else if (st_q == ST_XFER && ready) begin
         ptr_q <= (gnt_q == LAST_CH) ? '0 : gnt_q + IW'(1);
      end
   end

   // bus handover state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         gnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (any_req) st_q <= ST_WAIT_ACK;
            ST_WAIT_ACK: begin
               if (!any_req) begin
                  st_q <= ST_IDLE;
               end else if (hold_ack && pick_valid) begin
                  gnt_q <= pick_idx;
                  st_q  <= ST_XFER;
               end
            end
            ST_XFER: if (ready) st_q <= any_req ? ST_WAIT_ACK : ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign hold_req = (st_q != ST_IDLE);
   assign dack_act = (st_q == ST_XFER);

   always_comb begin
      dack_n = '1;
      if (dack_act) dack_n[gnt_q] = 1'b0;
   end

   p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dack_n));
   p_grant_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~dack_n)) && !$past(|(~dack_n))) |-> $past(hold_ack));
   p_hold_during_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~dack_n)) |-> hold_req);
   p_wait_keeps_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~dack_n)) && !ready) |=> $stable(dack_n));
   p_no_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~dack_n)) && !ready) |=> (|(~dack_n)));
   p_release_on_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~dack_n)) && ready && !cfg_we) |=> (&dack_n));
   p_drop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~dack_n)) && ready && !any_req) |=> !hold_req);
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [NCH-1:0] cfg_enable = '0;
   logic           cfg_rotate = 1'b0;
   logic [NCH-1:0] dreq = '0;
   logic           hold_ack = 1'b0;
   logic           ready = 1'b1;
   logic           hold_req;
   logic [NCH-1:0] dack_n;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_prio_arbiter #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
      .cfg_rotate(cfg_rotate), .dreq(dreq), .hold_ack(hold_ack), .ready(ready),
      .hold_req(hold_req), .dack_n(dack_n)
   );

   // {rotate, enable[3:0], request[3:0], expected first grant (7 = none)}
   localparam logic [11:0] VEC [8] = '{
      {1'b0, 4'hF, 4'b1000, 3'd3},
      {1'b0, 4'hF, 4'b0110, 3'd1},
      {1'b0, 4'h5, 4'b0010, 3'd7},
      {1'b0, 4'h5, 4'b1110, 3'd2},
      {1'b1, 4'hF, 4'b1100, 3'd2},
      {1'b0, 4'h8, 4'b1111, 3'd3},
      {1'b1, 4'h6, 4'b1001, 3'd7},
      {1'b0, 4'hF, 4'b1111, 3'd0}
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int grant_idx(input logic [NCH-1:0] d);
      int r = -1;
      for (int i = 0; i < NCH; i++) if (!d[i]) r = i;
      return r;
   endfunction

   task automatic cfg(input logic rot, input logic [NCH-1:0] en);
      @(negedge clk);
      cfg_we = 1'b1; cfg_rotate = rot; cfg_enable = en;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic get_grant(output int idx);
      idx = -1;
      for (int c = 0; c < 30 && idx < 0; c++) begin
         @(negedge clk);
         idx = grant_idx(dack_n);
      end
   endtask

   task automatic wait_release();
      for (int c = 0; c < 30 && dack_n != '1; c++) @(negedge clk);
   endtask

   task automatic go_idle();
      dreq = '0; ready = 1'b1;
      for (int c = 0; c < 30 && hold_req; c++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int g;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(hold_req == 1'b0, "R1 hold_req after reset", int'(hold_req), 0);
      chk(dack_n == 4'hF, "R1 dack_n after reset", int'(dack_n), 15);
      rst_n = 1'b1;
      hold_ack = 1'b1;
      dreq = 4'hF;
      repeat (8) @(negedge clk);
      chk(hold_req == 1'b0, "R1 disabled after reset", int'(hold_req), 0);
      go_idle();

      // R2: synchronizer latency, R3: no grant without hold_ack
      hold_ack = 1'b0;
      cfg(1'b0, 4'hF);
      @(negedge clk);
      dreq = 4'b0001;
      @(negedge clk); @(negedge clk);
      chk(hold_req == 1'b0, "R2 hold_req after 2 edges", int'(hold_req), 0);
      @(negedge clk);
      chk(hold_req == 1'b1, "R2 hold_req after 3 edges", int'(hold_req), 1);
      repeat (10) @(negedge clk);
      chk(dack_n == 4'hF, "R3 no grant without hold_ack", int'(dack_n), 15);
      hold_ack = 1'b1;
      get_grant(g);
      chk(g == 0, "R3 grant once hold_ack", g, 0);
      chk(hold_req == 1'b1, "R3 hold_req during grant", int'(hold_req), 1);
      go_idle();

      // R7/R8: wait states and no preemption
      ready = 1'b0;
      dreq = 4'b0100;
      get_grant(g);
      chk(g == 2, "R5 single request grant", g, 2);
      dreq = 4'b0101;
      repeat (6) @(negedge clk);
      chk(grant_idx(dack_n) == 2, "R8 no preemption", grant_idx(dack_n), 2);
      chk(dack_n == 4'b1011, "R7 grant held in wait", int'(dack_n), 11);
      ready = 1'b1;
      @(negedge clk);
      chk(dack_n == 4'hF, "R7 release after ready", int'(dack_n), 15);
      get_grant(g);
      chk(g == 0, "R5 fixed higher wins next", g, 0);
      // R9: hold drops once requests are gone
      dreq = '0;
      repeat (10) @(negedge clk);
      chk(hold_req == 1'b0, "R9 hold_req drops", int'(hold_req), 0);
      chk(dack_n == 4'hF, "R9 no grant when idle", int'(dack_n), 15);

      // R6: rotating order with all held
      cfg(1'b1, 4'hF);
      dreq = 4'hF;
      for (int k = 0; k < 6; k++) begin
         get_grant(g);
         chk(g == (k % NCH), "R6 rotating order", g, k % NCH);
         wait_release();
      end
      go_idle();

      // R5: fixed mode with all held keeps channel 0
      cfg(1'b0, 4'hF);
      dreq = 4'hF;
      for (int k = 0; k < 3; k++) begin
         get_grant(g);
         chk(g == 0, "R5 fixed repeat", g, 0);
         wait_release();
      end
      go_idle();

      // R6: served channel 2 makes channel 3 highest
      cfg(1'b1, 4'hF);
      ready = 1'b0;
      dreq = 4'b0100;
      get_grant(g);
      chk(g == 2, "R6 first rotating grant", g, 2);
      dreq = 4'b1010;
      repeat (4) @(negedge clk);
      ready = 1'b1;
      wait_release();
      get_grant(g);
      chk(g == 3, "R6 next after served", g, 3);
      go_idle();

      // R10/R2/R5: configuration vectors
      for (int v = 0; v < 8; v++) begin
         logic [11:0] e = VEC[v];
         cfg(e[11], e[10:7]);
         dreq = e[6:3];
         if (e[2:0] == 3'd7) begin
            repeat (10) @(negedge clk);
            chk(hold_req == 1'b0, "R2 disabled request ignored", int'(hold_req), 0);
            chk(dack_n == 4'hF, "R10 disabled no grant", int'(dack_n), 15);
         end else begin
            get_grant(g);
            chk(g == int'(e[2:0]), "R10 vector first grant", g, int'(e[2:0]));
         end
         go_idle();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule